// File: doc/BRIEF.md
# Global Shadow-Load Controller

This block decides when a group of shadowed configuration registers of a pulse-width modulator copies its pending values into the active set. Five register classes can take part: the dead-band control word, the action tables for channels A and B, and compare values A and B. Each class has its own enrol bit. On each accepted trigger, one registered strobe goes out to every enrolled class in the same clock cycle. A class that is not enrolled never receives a strobe. The shadow and active registers sit outside this block, and each holder latches its new value on its own strobe bit.

Four automatic trigger sources can be selected: counter-at-zero, counter-at-period, either of the two, or an external sync pulse. The automatic sources take effect only while a global enable is set. A software force command loads all enrolled classes at once, whatever the selected source and whatever the enable. The sync input can lag the counter event it was derived from by one or two clocks, and it can be more than one cycle wide. The controller therefore counts one trigger per sync pulse. After a strobe it also holds off further automatic triggers for a short guard window, so that two views of the same event merge into a single load. All pins are plain control pins. No data flows through the block, so it has no handshake.

Top module: `gsl_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every bit of load_o is 0.
- R2: With trig_sel_i = 0 (counter zero) and glb_en_i = 1, a cycle with ctr_zero_i high produces load_o equal to class_en_i in the next cycle. ctr_period_i has no effect in this mode.
- R3: A load_o bit whose class_en_i bit is 0 never goes high. The bit order is dead-band control = 0, action table A = 1, action table B = 2, compare A = 3, compare B = 4.
- R4: Every strobe drives all enrolled bits in the same cycle. A nonzero load_o equals the class_en_i value sampled with the trigger.
- R5: trig_sel_i = 1 triggers on ctr_period_i only. trig_sel_i = 2 triggers on either ctr_zero_i or ctr_period_i. Each produces a strobe one cycle later.
- R6: With trig_sel_i = 3, the rising edge of sync_i produces exactly one strobe two cycles after sync_i is first seen high, however many cycles the pulse lasts. Counter events are ignored in this mode.
- R7: force_i high for one cycle produces a strobe of class_en_i in the next cycle, whatever trig_sel_i and glb_en_i are. A force in the same cycle as an automatic trigger gives only one strobe.
- R8: While glb_en_i = 0, automatic triggers are ignored and are not stored. Setting glb_en_i afterwards produces no strobe for them.
- R9: A trig_sel_i value of 4 to 7 means force-only: zero, period and sync events produce no strobe.
- R10: After any strobe-producing cycle, automatic triggers in the next GUARD_CYC (default 2) cycles are merged into it and produce no strobe. An automatic trigger one cycle later produces a strobe.
- R11: load_o is a registered pulse. An automatic trigger never produces strobes in two consecutive cycles, and sync_i has no combinational path to load_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctr_zero_i | input | 1 | Time-base counter equals zero, single-cycle event |
| ctr_period_i | input | 1 | Time-base counter equals period, single-cycle event |
| sync_i | input | 1 | External sync pulse, one or more cycles wide |
| glb_en_i | input | 1 | Global enable for the automatic triggers |
| trig_sel_i | input | 3 | Trigger source: 0 zero, 1 period, 2 either, 3 sync, 4-7 force-only |
| class_en_i | input | 5 | Per-class enrol bits |
| force_i | input | 1 | Software force-load command |
| load_o | output | 5 | Per-class load strobes |

## Verification
A counter event or a force sampled on one rising edge shows on load_o in the cycle after that edge. A sync rising edge shows one cycle later still, because the sync path has an extra register stage. The driver task records each stimulus against the current cycle number and queues the expected mask at that cycle plus the latency of its source (one or two). The monitor samples on the falling edge. In every cycle it either matches load_o against the queued entry or requires load_o to be zero, so a strobe that is late, early, duplicated or missing is caught. Guard-window cases place the second event exactly on the last blocked cycle and on the first free cycle.

// File: rtl/gsl_pkg.sv
package gsl_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] TRG_ZERO   = 3'd0;
  localparam logic [SEL_W-1:0] TRG_PERIOD = 3'd1;
  localparam logic [SEL_W-1:0] TRG_EITHER = 3'd2;
  localparam logic [SEL_W-1:0] TRG_SYNC   = 3'd3;

  localparam int CLS_DBCTL = 0;
  localparam int CLS_ACTA  = 1;
  localparam int CLS_ACTB  = 2;
  localparam int CLS_CMPA  = 3;
  localparam int CLS_CMPB  = 4;
  localparam int CLS_COUNT = 5;
endpackage

// File: rtl/gsl_sync_edge.sv
module gsl_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic edge_o
);
  logic sync_q;
  logic sync_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync_q    <= sync_i;
      sync_prev <= sync_q;
    end
  end

  // edge comes from registers only: no path from the pin
  assign edge_o = sync_q & ~sync_prev;

  // R6: a wide pulse yields one edge
  a_r6_one_edge_per_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/gsl_trig_sel.sv
module gsl_trig_sel
  import gsl_pkg::*;
(
  input  logic             glb_en_i,
  input  logic [SEL_W-1:0] trig_sel_i,
  input  logic             ctr_zero_i,
  input  logic             ctr_period_i,
  input  logic             sync_edge_i,
  output logic             auto_hit_o
);
  logic src_hit;

  always_comb begin
    unique case (trig_sel_i)
      TRG_ZERO:   src_hit = ctr_zero_i;
      TRG_PERIOD: src_hit = ctr_period_i;
      TRG_EITHER: src_hit = ctr_zero_i | ctr_period_i;
      TRG_SYNC:   src_hit = sync_edge_i;
      default:    src_hit = 1'b0;
    endcase
  end

  assign auto_hit_o = glb_en_i & src_hit;
endmodule

// File: rtl/gsl_guard.sv
module gsl_guard #(
  parameter int GUARD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_hit_i,
  input  logic force_i,
  output logic fire_o
);
  logic busy;
  logic auto_fire;

  generate
    if (GUARD_CYC == 0) begin : g_noguard
      assign busy = 1'b0;
    end else begin : g_guard
      localparam int CW = $clog2(GUARD_CYC + 1);
      logic [CW-1:0] hold_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_cnt <= '0;
        end else if (fire_o) begin
          hold_cnt <= CW'(GUARD_CYC);
        end else if (hold_cnt != '0) begin
          hold_cnt <= hold_cnt - 1'b1;
        end
      end
      assign busy = (hold_cnt != '0);
    end
  endgenerate

  assign auto_fire = auto_hit_i & ~busy;
  assign fire_o    = force_i | auto_fire;

  // R10 / R11: accepted automatic triggers are never back to back
  if (GUARD_CYC > 0) begin : g_chk
    a_r10_auto_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      auto_fire |=> !auto_fire);
  end
endmodule

// File: rtl/gsl_fanout.sv
module gsl_fanout #(
  parameter int NCLS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  input  logic [NCLS-1:0] class_en_i,
  output logic [NCLS-1:0] load_o
);
  for (genvar i = 0; i < NCLS; i++) begin : g_cls
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_o[i] <= 1'b0;
      else        load_o[i] <= fire_i & class_en_i[i];
    end
  end

  // R3: no strobe to a class that was not enrolled
  a_r3_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o & ~$past(class_en_i)) == '0);
endmodule

// File: rtl/gsl_ctrl.sv
module gsl_ctrl
  import gsl_pkg::*;
#(
  parameter int NUM_CLASSES = CLS_COUNT,
  parameter int GUARD_CYC   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctr_zero_i,
  input  logic                   ctr_period_i,
  input  logic                   sync_i,
  input  logic                   glb_en_i,
  input  logic [SEL_W-1:0]       trig_sel_i,
  input  logic [NUM_CLASSES-1:0] class_en_i,
  input  logic                   force_i,
  output logic [NUM_CLASSES-1:0] load_o
);
  logic sync_edge;
  logic auto_hit;
  logic fire;

  gsl_sync_edge u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .edge_o (sync_edge)
  );

  gsl_trig_sel u_sel (
    .glb_en_i     (glb_en_i),
    .trig_sel_i   (trig_sel_i),
    .ctr_zero_i   (ctr_zero_i),
    .ctr_period_i (ctr_period_i),
    .sync_edge_i  (sync_edge),
    .auto_hit_o   (auto_hit)
  );

  gsl_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_hit_i (auto_hit),
    .force_i    (force_i),
    .fire_o     (fire)
  );

  gsl_fanout #(.NCLS(NUM_CLASSES)) u_fan (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fire),
    .class_en_i (class_en_i),
    .load_o     (load_o)
  );

  // R1: idle out of reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> load_o == '0);

  // R4: all enrolled classes strobe together
  a_r4_all_enrolled: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_o) |-> load_o == $past(class_en_i));

  // R8: a strobe needs either the global enable or a force
  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_o) |-> $past(glb_en_i || force_i));

  // R9: force-only selections ignore every event
  a_r9_force_only: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel_i > TRG_SYNC && !force_i) |=> load_o == '0);
endmodule

// File: tb/gsl_ctrl_test.sv
module gsl_ctrl_test;
  localparam int NC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctr_zero_i = 1'b0;
  logic          ctr_period_i = 1'b0;
  logic          sync_i = 1'b0;
  logic          glb_en_i = 1'b0;
  logic [2:0]    trig_sel_i = 3'd0;
  logic [NC-1:0] class_en_i = '0;
  logic          force_i = 1'b0;
  logic [NC-1:0] load_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int            q_cyc[$];
  logic [NC-1:0] q_mask[$];
  string         q_tag[$];

  gsl_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctr_zero_i   (ctr_zero_i),
    .ctr_period_i (ctr_period_i),
    .sync_i       (sync_i),
    .glb_en_i     (glb_en_i),
    .trig_sel_i   (trig_sel_i),
    .class_en_i   (class_en_i),
    .force_i      (force_i),
    .load_o       (load_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_strobe(input int dly, input logic [NC-1:0] m, input string tag);
    q_cyc.push_back(cyc + dly);
    q_mask.push_back(m);
    q_tag.push_back(tag);
  endtask

  // drive events for `wid` cycles, starting at the next falling edge
  task automatic drive(input bit z, input bit p, input bit s, input bit f, input int wid);
    @(negedge clk);
    ctr_zero_i = z; ctr_period_i = p; sync_i = s; force_i = f;
    repeat (wid) @(negedge clk);
    ctr_zero_i = 0; ctr_period_i = 0; sync_i = 0; force_i = 0;
  endtask

  // one-cycle event with its expected strobe queued at drive time
  task automatic pulse(input bit z, input bit p, input bit s, input bit f,
                       input int dly, input logic [NC-1:0] m, input string tag);
    @(negedge clk);
    ctr_zero_i = z; ctr_period_i = p; sync_i = s; force_i = f;
    if (dly > 0) expect_strobe(dly, m, tag);
    @(negedge clk);
    ctr_zero_i = 0; ctr_period_i = 0; sync_i = 0; force_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        checks++;
        if (load_o !== q_mask[0]) begin
          errors++;
          $display("FAIL %s cyc=%0d act=%h exp=%h", q_tag[0], cyc, load_o, q_mask[0]);
        end
        void'(q_cyc.pop_front()); void'(q_mask.pop_front()); void'(q_tag.pop_front());
      end else if (load_o !== '0) begin
        errors++;
        $display("FAIL R8/R10 unexpected strobe cyc=%0d act=%h exp=0", cyc, load_o);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    checks++;
    if (load_o !== '0) begin
      errors++;
      $display("FAIL R1 reset act=%h exp=0", load_o);
    end
    rst_n = 1'b1;
    idle(1);
    checks++;
    if (load_o !== '0) begin
      errors++;
      $display("FAIL R1 after release act=%h exp=0", load_o);
    end

    // R2: zero mode, all classes; period ignored
    glb_en_i = 1; trig_sel_i = 3'd0; class_en_i = 5'h1F;
    pulse(1, 0, 0, 0, 1, 5'h1F, "R2 zero mode");
    idle(4);
    pulse(0, 1, 0, 0, 0, '0, "");
    idle(4);

    // R3 / R4: partial enrolment
    class_en_i = 5'b01011;
    pulse(1, 0, 0, 0, 1, 5'b01011, "R3 R4 partial enrol");
    idle(4);

    // R5: period mode, zero ignored
    trig_sel_i = 3'd1; class_en_i = 5'b10100;
    pulse(0, 1, 0, 0, 1, 5'b10100, "R5 period mode");
    idle(4);
    pulse(1, 0, 0, 0, 0, '0, "");
    idle(4);

    // R5: either mode
    trig_sel_i = 3'd2; class_en_i = 5'h1F;
    pulse(1, 0, 0, 0, 1, 5'h1F, "R5 either zero");
    idle(4);
    pulse(0, 1, 0, 0, 1, 5'h1F, "R5 either period");
    idle(4);

    // R10: second event on last blocked cycle is merged
    pulse(1, 0, 0, 0, 1, 5'h1F, "R10 first of pair");
    pulse(0, 1, 0, 0, 0, '0, "");
    idle(5);
    // R10: first free cycle is accepted
    pulse(1, 0, 0, 0, 1, 5'h1F, "R10 first");
    idle(1);
    pulse(0, 1, 0, 0, 1, 5'h0F & 5'h1F | 5'h10, "R10 after window");
    idle(5);

    // R6: sync mode, one-cycle pulse
    trig_sel_i = 3'd3; class_en_i = 5'b00110;
    pulse(0, 0, 1, 0, 2, 5'b00110, "R6 sync single");
    idle(4);
    // R6: wide pulse gives one strobe
    @(negedge clk); expect_strobe(3, 5'b00110, "R6 sync wide");
    drive(0, 0, 1, 0, 3);
    idle(5);
    // R6: zero then lagging sync, one strobe from sync only
    pulse(1, 0, 0, 0, 0, '0, "");
    pulse(0, 0, 1, 0, 2, 5'b00110, "R6 zero plus lagging sync");
    idle(5);

    // R7: force with enable off
    glb_en_i = 0; trig_sel_i = 3'd0; class_en_i = 5'b11001;
    pulse(0, 0, 0, 1, 1, 5'b11001, "R7 force while disabled");
    idle(4);
    // R7: force coincident with zero, single strobe
    glb_en_i = 1;
    pulse(1, 0, 0, 1, 1, 5'b11001, "R7 force with zero");
    idle(5);

    // R8: disabled triggers ignored and not stored
    glb_en_i = 0;
    pulse(1, 0, 0, 0, 0, '0, "");
    idle(2);
    pulse(1, 0, 0, 0, 0, '0, "");
    idle(2);
    glb_en_i = 1;
    idle(6);
    checks++;
    if (load_o !== '0) begin
      errors++;
      $display("FAIL R8 not latched act=%h exp=0", load_o);
    end

    // R9: force-only selection
    trig_sel_i = 3'd5; class_en_i = 5'h1F;
    pulse(1, 0, 0, 0, 0, '0, "");
    idle(3);
    pulse(0, 1, 0, 0, 0, '0, "");
    idle(3);
    pulse(0, 0, 1, 0, 0, '0, "");
    idle(4);
    pulse(0, 0, 0, 1, 1, 5'h1F, "R9 force in force-only");
    idle(4);

    // R11: one-cycle pulse, next cycle checked idle by monitor
    trig_sel_i = 3'd0; class_en_i = 5'b00001;
    pulse(1, 0, 0, 0, 1, 5'b00001, "R11 single pulse");
    idle(3);

    // R3: nothing enrolled
    class_en_i = '0;
    pulse(0, 0, 0, 1, 1, 5'b00000, "R3 no class enrolled");
    idle(5);

    checks++;
    if (q_cyc.size() != 0) begin
      errors++;
      $display("FAIL R4 missing strobes act=%0d exp=0", q_cyc.size());
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule